// File: doc/BRIEF.md
# DDR2 Memory Controller Control/Status Register Block

This block is the software-visible register front end of a DDR2 SDRAM controller. It covers only the step that turns external memory on: software writes a mode-register-set command bit, the block records that memory initialisation has finished and raises a level memory-enable output that the system interconnect uses to open the memory address range. It also holds a configuration register, a bank of general timing/ECC setting registers with no side effects, and a fixed revision code.

Access is over a simple single-cycle 32-bit register bus (select, write enable, 12-bit byte address, write data, registered read data) decoding a 4 KiB window. Accesses to undefined, read-only-for-write or misaligned locations are absorbed and reported by a one-cycle error pulse. A boot-preserve input lets the enabled state of memory survive a reset, for example when a boot stage has already initialised it.

The initialisation state is a two-state machine. State UNINIT (memory off) moves to state READY (memory on) on transition MRS_ACCEPT, a write to the status register with bit 0 set. READY has no exit while reset is released (transition HOLD). A reset takes READY back to UNINIT (transition RESET_DROP) unless boot-preserve is high, in which case READY is kept (transition RESET_KEEP); UNINIT always stays UNINIT under reset.

Top module: `ddr_csr_top`

## Requirements
- R1: The configuration register (byte offset 0x000) stores only bits [15:0] of a write; bits [31:16] always read back as zero.
- R2: A write to the status register (offset 0x004) stores only bits [5:0]; bits [7:6] and [31:9] read as zero, and bit 8 (init complete) is not changed by any written value.
- R3: Writing bit 0 = 1 to the status register while in UNINIT moves the block to READY: status bit 8 reads 1, status bit 0 reads 0, and mem_en is 1 from the cycle after the write.
- R4: In READY, further writes with bit 0 set store bit 0 as written (bit 0 reads back 1), bit 8 stays 1 and mem_en stays 1.
- R5: Offsets 0x008 through 0x04C are 18 independent 32-bit read/write registers that store all 32 bits.
- R6: A read of offset 0x050 always returns 0x00000100; a write to it changes nothing and is reported as an error.
- R7: Any access to an offset above 0x050 reads zero, has no effect on any register, and gives err_pulse = 1 in the cycle after the access; valid accesses and idle cycles give err_pulse = 0.
- R8: An access whose address bits [1:0] are not 00 is invalid: a read returns zero, a write changes nothing, and err_pulse is 1 in the next cycle.
- R9: Read data appears on rdata in the cycle after a read is presented and holds its value through cycles with no read.
- R10: Reset with boot_keep = 0 clears all stored registers, rdata and err_pulse to zero and leaves the block in UNINIT with mem_en = 0; mem_en never falls while reset is released.
- R11: Reset with boot_keep = 1 while in READY clears every stored register but keeps READY: mem_en stays 1 and status bit 8 reads 1 right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_keep | input | 1 | Keep the memory-enabled state through reset when high |
| sel | input | 1 | Register access request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address inside the 4 KiB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| mem_en | output | 1 | Level enable for the external memory range (READY state) |
| err_pulse | output | 1 | One-cycle pulse after an invalid access |

## Verification
The assertions assume one access per cycle, that addr, wr and wdata are only meaningful while sel is high, and that reset is held for at least one full clock edge; the stimulus drives every input on the falling edge and keeps sel low during reset cycles. They also assume the boot-preserve input is only relevant while rst_n is low, which the bench respects by changing it only together with reset. A scoreboard compares each read's data and each access's error flag one cycle after the access, while mem_en is checked directly around the command write and both reset flavours.

// File: rtl/ddr_csr_pkg.sv
package ddr_csr_pkg;

    // Initialisation state of the external memory
    typedef enum logic [0:0] {
        ST_UNINIT = 1'b0,
        ST_READY  = 1'b1
    } init_state_e;

    // Decoded target of a register access
    typedef enum logic [2:0] {
        RG_CFG  = 3'd0,
        RG_STAT = 3'd1,
        RG_SCR  = 3'd2,
        RG_REV  = 3'd3,
        RG_BAD  = 3'd4
    } region_e;

    // Status register layout (decoded by software)
    localparam int STAT_LO_W = 6;
    localparam int INIT_BIT  = 8;
    localparam int MRS_BIT   = 0;

endpackage

// File: rtl/ddr_csr_decode.sv
module ddr_csr_decode
    import ddr_csr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SCRATCH_N = 18,
    parameter int IDX_W     = $clog2(SCRATCH_N)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output region_e           region,
    output logic [IDX_W-1:0]  scr_idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_CFG  = WORD_W'(0);
    localparam logic [WORD_W-1:0] W_STAT = WORD_W'(1);
    localparam logic [WORD_W-1:0] W_SCR0 = WORD_W'(2);
    localparam logic [WORD_W-1:0] W_REV  = WORD_W'(2 + SCRATCH_N);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] scr_off;

    assign word    = addr[ADDR_W-1:2];
    assign scr_off = word - W_SCR0;
    assign scr_idx = scr_off[IDX_W-1:0];

    always_comb begin
        region = RG_BAD;
        if (addr[1:0] == 2'b00) begin
            if (word == W_CFG) begin
                region = RG_CFG;
            end else if (word == W_STAT) begin
                region = RG_STAT;
            end else if (word >= W_SCR0 && word < W_REV) begin
                region = RG_SCR;
            end else if (word == W_REV && !wr) begin
                region = RG_REV;
            end
        end
    end

endmodule

// File: rtl/ddr_csr_init_fsm.sv
module ddr_csr_init_fsm
    import ddr_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        boot_keep,
    input  logic        mrs_req,
    output init_state_e state,
    output logic        init_done
);
    init_state_e state_nxt;

    // State register: reset drops READY unless boot_keep asks to keep it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (state == ST_READY && boot_keep) begin
                state <= ST_READY;      // RESET_KEEP
            end else begin
                state <= ST_UNINIT;     // RESET_DROP
            end
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_UNINIT: begin
                if (mrs_req) begin
                    state_nxt = ST_READY;   // MRS_ACCEPT
                end
            end
            ST_READY: begin
                state_nxt = ST_READY;       // HOLD
            end
            default: state_nxt = ST_UNINIT;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_UNINIT: init_done = 1'b0;
            ST_READY:  init_done = 1'b1;
            default:   init_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/ddr_csr_regfile.sv
module ddr_csr_regfile
    import ddr_csr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CFG_W     = 16,
    parameter int SCRATCH_N = 18,
    parameter int IDX_W     = $clog2(SCRATCH_N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_cfg,
    input  logic                 we_stat,
    input  logic                 we_scr,
    input  logic [IDX_W-1:0]     scr_idx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 init_done,
    output logic [CFG_W-1:0]     cfg_q,
    output logic [STAT_LO_W-1:0] stat_lo_q,
    output logic [DATA_W-1:0]    scr_rd
);
    logic [DATA_W-1:0]    scr_q [SCRATCH_N];
    logic [STAT_LO_W-1:0] stat_lo_nxt;

    // Command bit self-clears only when it triggers the init step
    always_comb begin
        stat_lo_nxt = wdata[STAT_LO_W-1:0];
        if (!init_done && wdata[MRS_BIT]) begin
            stat_lo_nxt[MRS_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            stat_lo_q <= '0;
        end else begin
            if (we_cfg) begin
                cfg_q <= wdata[CFG_W-1:0];
            end
            if (we_stat) begin
                stat_lo_q <= stat_lo_nxt;
            end
        end
    end

    for (genvar g = 0; g < SCRATCH_N; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scr_q[g] <= '0;
            end else if (we_scr && scr_idx == IDX_W'(g)) begin
                scr_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        scr_rd = '0;
        for (int k = 0; k < SCRATCH_N; k++) begin
            if (scr_idx == IDX_W'(k)) begin
                scr_rd = scr_q[k];
            end
        end
    end

endmodule

// File: rtl/ddr_csr_top.sv
module ddr_csr_top
    import ddr_csr_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 32,
    parameter int          CFG_W     = 16,
    parameter int          SCRATCH_N = 18,
    parameter logic [31:0] REV_CODE  = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_keep,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_en,
    output logic              err_pulse
);
    localparam int IDX_W = $clog2(SCRATCH_N);

    region_e              region;
    logic [IDX_W-1:0]     scr_idx;
    init_state_e          state;
    logic                 init_done;
    logic [CFG_W-1:0]     cfg_q;
    logic [STAT_LO_W-1:0] stat_lo_q;
    logic [DATA_W-1:0]    scr_rd;
    logic [DATA_W-1:0]    rd_mux;
    logic                 do_wr;
    logic                 mrs_req;

    assign do_wr   = sel && wr;
    assign mrs_req = do_wr && region == RG_STAT && wdata[MRS_BIT];

    ddr_csr_decode #(
        .ADDR_W    (ADDR_W),
        .SCRATCH_N (SCRATCH_N),
        .IDX_W     (IDX_W)
    ) decode_i (
        .addr    (addr),
        .wr      (wr),
        .region  (region),
        .scr_idx (scr_idx)
    );

    ddr_csr_init_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_keep (boot_keep),
        .mrs_req   (mrs_req),
        .state     (state),
        .init_done (init_done)
    );

    ddr_csr_regfile #(
        .DATA_W    (DATA_W),
        .CFG_W     (CFG_W),
        .SCRATCH_N (SCRATCH_N),
        .IDX_W     (IDX_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_cfg    (do_wr && region == RG_CFG),
        .we_stat   (do_wr && region == RG_STAT),
        .we_scr    (do_wr && region == RG_SCR),
        .scr_idx   (scr_idx),
        .wdata     (wdata),
        .init_done (init_done),
        .cfg_q     (cfg_q),
        .stat_lo_q (stat_lo_q),
        .scr_rd    (scr_rd)
    );

    // Read selection
    always_comb begin
        rd_mux = '0;
        unique case (region)
            RG_CFG:  rd_mux[CFG_W-1:0] = cfg_q;
            RG_STAT: begin
                rd_mux[STAT_LO_W-1:0] = stat_lo_q;
                rd_mux[INIT_BIT]      = init_done;
            end
            RG_SCR:  rd_mux = scr_rd;
            RG_REV:  rd_mux = DATA_W'(REV_CODE);
            RG_BAD:  rd_mux = '0;
            default: rd_mux = '0;
        endcase
    end

    // Registered read data and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata     <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= sel && region == RG_BAD;
            if (sel && !wr) begin
                rdata <= rd_mux;
            end
        end
    end

    assign mem_en = (state == ST_READY);

endmodule

// File: rtl/ddr_csr_chk.sv
module ddr_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        wr,
    input logic [11:0] addr,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        mem_en,
    input logic        err_pulse
);
    logic bad_acc;
    assign bad_acc = (addr[1:0] != 2'b00) || (addr > 12'h050) || (wr && addr == 12'h050);

    assert_mrs_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == 12'h004 && wdata[0] && !mem_en) |=> mem_en);

    assert_en_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$fell(mem_en));

    assert_stat_bit8_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == 12'h004) |=> rdata[8] == $past(mem_en));

    assert_cfg_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == 12'h000) |=> rdata[31:16] == 16'h0);

    assert_rev_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == 12'h050) |=> rdata == 32'h0000_0100);

    assert_bad_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && bad_acc) |=> err_pulse);

    assert_good_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || !bad_acc) |=> !err_pulse);

    assert_misalign_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr[1:0] != 2'b00) |=> rdata == 32'h0);

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |=> $stable(rdata));

endmodule

bind ddr_csr_top ddr_csr_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr        (wr),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .mem_en    (mem_en),
    .err_pulse (err_pulse)
);

// File: tb/ddr_csr_top_tb_top.sv
module ddr_csr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_keep = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        mem_en;
    logic        err_pulse;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;
    logic acc_seen = 1'b0;

    // Scoreboard queues: one entry per access
    logic        q_is_rd [$];
    logic [31:0] q_exp   [$];
    logic        q_err   [$];
    string       q_req   [$];

    always #2.5 clk = ~clk;

    ddr_csr_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_keep (boot_keep),
        .sel       (sel),
        .wr        (wr),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .mem_en    (mem_en),
        .err_pulse (err_pulse)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic bad_addr(input logic w, input logic [11:0] a);
        return (a[1:0] != 2'b00) || (a > 12'h050) || (w && a == 12'h050);
    endfunction

    // Driver: drive on falling edge, push expectation
    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          input logic [31:0] exp, input string req);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        q_is_rd.push_back(!w);
        q_exp.push_back(exp);
        q_err.push_back(bad_addr(w, a));
        q_req.push_back(req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sel = 1'b0; wr = 1'b0;
        end
    endtask

    task automatic do_reset(input logic keep);
        @(negedge clk);
        sel = 1'b0; rst_n = 1'b0; boot_keep = keep;
        @(negedge clk);
        rst_n = 1'b1; boot_keep = 1'b0;
    endtask

    always @(posedge clk) acc_seen <= rst_n && sel;

    // Monitor: compare one cycle after each access
    always @(negedge clk) begin
        if (acc_seen && q_exp.size() > 0) begin
            logic        is_rd;
            logic [31:0] exp;
            logic        e;
            string       r;
            is_rd = q_is_rd.pop_front();
            exp   = q_exp.pop_front();
            e     = q_err.pop_front();
            r     = q_req.pop_front();
            if (is_rd) check(rdata == exp, r, rdata, exp);
            check(err_pulse == e, {r, " err_pulse"}, {31'b0, err_pulse}, {31'b0, e});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        idle(1);
        // R10: reset state
        check(mem_en == 1'b0, "R10 mem_en after reset", {31'b0, mem_en}, 32'h0);
        check(rdata == 32'h0, "R10 rdata after reset", rdata, 32'h0);
        check(err_pulse == 1'b0, "R10 err after reset", {31'b0, err_pulse}, 32'h0);
        access(1'b0, 12'h004, 0, 32'h0, "R10 status after reset");
        access(1'b0, 12'h000, 0, 32'h0, "R10 cfg after reset");

        // R1: configuration width
        access(1'b1, 12'h000, 32'hDEAD_BEEF, 0, "R1 cfg write");
        access(1'b0, 12'h000, 0, 32'h0000_BEEF, "R1 cfg read");

        // R2: status masking, no init
        access(1'b1, 12'h004, 32'h0000_003E, 0, "R2 stat write");
        access(1'b0, 12'h004, 0, 32'h0000_003E, "R2 stat read");
        access(1'b1, 12'h004, 32'hFFFF_FFFE, 0, "R2 stat write all");
        access(1'b0, 12'h004, 0, 32'h0000_003E, "R2 stat masked read");
        idle(1);
        check(mem_en == 1'b0, "R2 mem_en still low", {31'b0, mem_en}, 32'h0);

        // R3: command triggers init
        access(1'b1, 12'h004, 32'h0000_0001, 0, "R3 mrs write");
        check(mem_en == 1'b0, "R3 mem_en before edge", {31'b0, mem_en}, 32'h0);
        idle(1);
        check(mem_en == 1'b1, "R3 mem_en after write", {31'b0, mem_en}, 32'h1);
        access(1'b0, 12'h004, 0, 32'h0000_0100, "R3 stat after init");

        // R4: repeat command after init
        access(1'b1, 12'h004, 32'h0000_0021, 0, "R4 repeat mrs");
        access(1'b0, 12'h004, 0, 32'h0000_0121, "R4 stat read");
        idle(1);
        check(mem_en == 1'b1, "R4 mem_en stays", {31'b0, mem_en}, 32'h1);

        // R5: scratch bank
        for (int i = 0; i < 18; i++)
            access(1'b1, 12'(12'h008 + 4 * i), 32'h9E37_79B9 * (i + 1), 0, "R5 scratch write");
        for (int i = 0; i < 18; i++)
            access(1'b0, 12'(12'h008 + 4 * i), 0, 32'h9E37_79B9 * (i + 1), "R5 scratch read");

        // R6: revision
        access(1'b0, 12'h050, 0, 32'h0000_0100, "R6 rev read");
        access(1'b1, 12'h050, 32'hFFFF_FFFF, 0, "R6 rev write");
        access(1'b0, 12'h050, 0, 32'h0000_0100, "R6 rev after write");

        // R7: undefined offsets
        access(1'b0, 12'h054, 0, 32'h0, "R7 read 0x054");
        access(1'b1, 12'h800, 32'h0000_5555, 0, "R7 write 0x800");
        access(1'b1, 12'hFFC, 32'h0000_7777, 0, "R7 write 0xFFC");
        access(1'b0, 12'h000, 0, 32'h0000_BEEF, "R7 cfg untouched");
        access(1'b0, 12'h04C, 0, 32'h9E37_79B9 * 18, "R7 last scratch untouched");

        // R8: misaligned
        access(1'b1, 12'h002, 32'h0000_1234, 0, "R8 misaligned write");
        access(1'b0, 12'h005, 0, 32'h0, "R8 misaligned read");
        access(1'b0, 12'h000, 0, 32'h0000_BEEF, "R8 cfg untouched");

        // R9: hold between reads
        access(1'b0, 12'h050, 0, 32'h0000_0100, "R9 read");
        idle(3);
        check(rdata == 32'h0000_0100, "R9 rdata holds", rdata, 32'h0000_0100);
        check(err_pulse == 1'b0, "R7 idle no err", {31'b0, err_pulse}, 32'h0);

        // R11: preserving reset
        do_reset(1'b1);
        check(mem_en == 1'b1, "R11 mem_en kept", {31'b0, mem_en}, 32'h1);
        access(1'b0, 12'h004, 0, 32'h0000_0100, "R11 stat bit8 kept");
        access(1'b0, 12'h000, 0, 32'h0, "R11 cfg cleared");
        access(1'b0, 12'h008, 0, 32'h0, "R11 scratch cleared");
        idle(2);

        // R10: plain reset drops init
        do_reset(1'b0);
        check(mem_en == 1'b0, "R10 mem_en dropped", {31'b0, mem_en}, 32'h0);
        access(1'b0, 12'h004, 0, 32'h0, "R10 stat cleared");
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule